// File: doc/BRIEF.md
# Protected DMA Loader with Apertures

This block is the DMA engine of a small microcontroller subsystem. It copies blocks of 32-bit words between external memory and one of the two local memories: the instruction store or the data store. Copies run in either direction. Its typical use is to pull boot code into local memory before the core is released. Software sets up a transfer through a small register port. The transfer holds an aperture code that picks the external target, the local memory select, a local word offset, an external byte address, a word count and the requester's privilege level. A start bit then launches the transfer.

Every external access is checked by a built-in physical memory protection unit before it goes out. The unit holds a programmable set of regions. Each region has a byte range, read and write enables, and a minimum privilege level. The transfer is cut into fixed-size chunks. Each chunk is checked as a whole before any of its words are issued. A denied chunk stops the transfer, records the faulting address and raises a one-cycle interrupt. Words already copied stay where they are.

Top module: `prot_dma_loader`

## Requirements
- R1: Register map (word address on `reg_addr`):
  - 0 is control: bit0 start, bit1 direction (1 = local to external), bit2 local select (0 = instruction, 1 = data), bits5:4 aperture, bits7:6 privilege.
  - 1 is the local word offset, 2 is the external byte address (the low two bits are ignored) and 3 is the length in words.
  - For region i: 8+4i is the base, 9+4i is the inclusive byte limit, and 10+4i holds the permissions (bit0 read, bit1 write, bits3:2 minimum privilege).
- R2: The aperture code of the running transfer appears on `ext_aperture` with every external request. Code 0 is device-local frame memory, 1 is coherent system memory and 2 is non-coherent system memory. Code 3 is reserved and is rejected as a configuration error.
- R3: With direction 0, word k of the transfer is read from external byte address base+4k and written to local word offset+k of the selected memory.
- R4: With direction 1, local word offset+k of the selected memory is written to external byte address base+4k.
- R5: A chunk is allowed only if some region contains its whole byte range, enables the access type (read for direction 0, write for direction 1) and has a minimum privilege no higher than the requester's. After reset no region grants anything.
- R6: The protection check is made once per chunk of CHUNK_WORDS words (default 64 words, 256 bytes), before any access of that chunk. A chunk that spans two regions is denied even if each region alone would allow its part.
- R7: On a denied chunk the transfer stops and sets `err_prot`. `fault_addr` takes the first byte address of that chunk, `irq` pulses for exactly one cycle, and words copied by earlier chunks are kept.
- R8: `busy` is high from the accepted start until the last write of the transfer completes. A start written while `busy` is high is ignored.
- R9: A zero length, a reserved aperture, or a local range (offset + length) past the end of the selected memory sets `err_cfg`. No external or local memory access is made.
- R10: `ext_req` stays high with a stable address until `ext_ack`. For reads, `ext_rdata` is taken in the `ext_ack` cycle. Local reads return `lmem_rdata` one cycle after `lmem_re`.
- R11: Reset leaves the engine idle: no request, both error flags clear, no interrupt, and all regions cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| ext_req | output | 1 | External access request |
| ext_we | output | 1 | External access is a write |
| ext_aperture | output | 2 | External target code |
| ext_addr | output | 32 | External byte address |
| ext_wdata | output | 32 | External write data |
| ext_ack | input | 1 | External access completion |
| ext_rdata | input | 32 | External read data |
| lmem_re | output | 1 | Local memory read strobe |
| lmem_we | output | 1 | Local memory write strobe |
| lmem_sel | output | 1 | Local memory select (0 instruction, 1 data) |
| lmem_addr | output | LA_W | Local word address |
| lmem_wdata | output | 32 | Local write data |
| lmem_rdata | input | 32 | Local read data, one cycle after read strobe |
| busy | output | 1 | Transfer in progress |
| err_cfg | output | 1 | Last start rejected for configuration |
| err_prot | output | 1 | Last transfer stopped by protection |
| fault_addr | output | 32 | First byte address of the denied chunk |
| irq | output | 1 | One-cycle protection fault interrupt |

## Verification
The bench builds the engine with a 32-word instruction store, a 16-word data store and 4-word chunks. With these sizes a ten-word copy crosses chunk boundaries twice. A data-store range can be made to end exactly at the last word, or to run one word past it. A transfer can pass its first chunk and then be denied in the next, so that the partial copy can be checked word by word. Region boundaries placed on chunk-unaligned addresses make a single chunk straddle two regions.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LEN_W = 16;

    typedef enum logic [1:0] {
        APT_FRAME  = 2'd0,
        APT_SYS_CO = 2'd1,
        APT_SYS_NC = 2'd2,
        APT_RSVD   = 2'd3
    } apt_e;

    typedef struct packed {
        logic        to_ext;
        logic        dsel;
        apt_e        apt;
        logic [1:0]  pl;
    } xfer_ctrl_t;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] limit;
        logic          rd;
        logic          wr;
        logic [1:0]    min_pl;
    } region_t;

    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_LRD, S_LCAP, S_EXT, S_LWR
    } st_e;

    // A region grants a chunk only if it covers the whole byte span.
    function automatic logic region_grants(region_t r, logic [AW-1:0] lo,
                                           logic [AW-1:0] hi, logic is_wr,
                                           logic [1:0] pl);
        return (lo >= r.base) && (hi <= r.limit) &&
               (is_wr ? r.wr : r.rd) && (pl >= r.min_pl);
    endfunction
endpackage

// File: rtl/pdl_regs.sv
module pdl_regs
    import pdl_pkg::*;
#(
    parameter int NREG = 4,
    parameter int RA_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              busy,
    output logic              go_q,
    output xfer_ctrl_t        ctrl,
    output logic [LEN_W-1:0]  loff,
    output logic [AW-3:0]     ext_word,
    output logic [LEN_W-1:0]  len,
    output region_t           regions [NREG]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            go_q     <= 1'b0;
            ctrl     <= '0;
            loff     <= '0;
            ext_word <= '0;
            len      <= '0;
        end else begin
            // start is only taken when written while the engine is idle
            go_q <= reg_we && (reg_addr == RA_W'(0)) && reg_wdata[0] && !busy;
            if (reg_we) begin
                case (reg_addr)
                    RA_W'(0): ctrl <= '{to_ext: reg_wdata[1], dsel: reg_wdata[2],
                                        apt: apt_e'(reg_wdata[5:4]), pl: reg_wdata[7:6]};
                    RA_W'(1): loff     <= reg_wdata[LEN_W-1:0];
                    RA_W'(2): ext_word <= reg_wdata[AW-1:2];
                    RA_W'(3): len      <= reg_wdata[LEN_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_region
        always_ff @(posedge clk) begin
            if (rst) begin
                regions[g] <= '0;
            end else if (reg_we) begin
                if (reg_addr == RA_W'(8 + 4*g))  regions[g].base  <= reg_wdata;
                if (reg_addr == RA_W'(9 + 4*g))  regions[g].limit <= reg_wdata;
                if (reg_addr == RA_W'(10 + 4*g)) begin
                    regions[g].rd     <= reg_wdata[0];
                    regions[g].wr     <= reg_wdata[1];
                    regions[g].min_pl <= reg_wdata[3:2];
                end
            end
        end
    end
endmodule

// File: rtl/pdl_pmp.sv
module pdl_pmp
    import pdl_pkg::*;
#(
    parameter int NREG = 4
) (
    input  region_t        regions [NREG],
    input  logic [AW-1:0]  lo,
    input  logic [AW-1:0]  hi,
    input  logic           is_wr,
    input  logic [1:0]     pl,
    output logic           allow
);
    logic [NREG-1:0] hit;

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign hit[g] = region_grants(regions[g], lo, hi, is_wr, pl);
    end

    assign allow = |hit;
endmodule

// File: rtl/prot_dma_loader.sv
module prot_dma_loader
    import pdl_pkg::*;
#(
    parameter int IMEM_WORDS  = 1024,
    parameter int DMEM_WORDS  = 512,
    parameter int CHUNK_WORDS = 64,
    parameter int NREG        = 4,
    localparam int LA_W = $clog2(IMEM_WORDS > DMEM_WORDS ? IMEM_WORDS : DMEM_WORDS),
    localparam int RA_W = $clog2(8 + 4*NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic             ext_req,
    output logic             ext_we,
    output logic [1:0]       ext_aperture,
    output logic [31:0]      ext_addr,
    output logic [31:0]      ext_wdata,
    input  logic             ext_ack,
    input  logic [31:0]      ext_rdata,
    output logic             lmem_re,
    output logic             lmem_we,
    output logic             lmem_sel,
    output logic [LA_W-1:0]  lmem_addr,
    output logic [31:0]      lmem_wdata,
    input  logic [31:0]      lmem_rdata,
    output logic             busy,
    output logic             err_cfg,
    output logic             err_prot,
    output logic [31:0]      fault_addr,
    output logic             irq
);
    logic              go_q;
    xfer_ctrl_t        ctrl, cur;
    logic [LEN_W-1:0]  loff, len, rem, cnt, chunk_n;
    logic [AW-3:0]     ext_word;
    region_t           regions [NREG];
    st_e               st, adv_st;
    logic [LA_W-1:0]   lptr;
    logic [AW-1:0]     eptr, chunk_hi;
    logic [DW-1:0]     wbuf;
    logic [LEN_W:0]    lend;
    logic              cfg_bad, allow;

    pdl_regs #(.NREG(NREG), .RA_W(RA_W)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .go_q(go_q), .ctrl(ctrl),
        .loff(loff), .ext_word(ext_word), .len(len), .regions(regions)
    );

    assign chunk_n  = (rem > LEN_W'(CHUNK_WORDS)) ? LEN_W'(CHUNK_WORDS) : rem;
    assign chunk_hi = eptr + (AW'(chunk_n) << 2) - AW'(1);

    pdl_pmp #(.NREG(NREG)) u_pmp (
        .regions(regions), .lo(eptr), .hi(chunk_hi),
        .is_wr(cur.to_ext), .pl(cur.pl), .allow(allow)
    );

    always_comb begin
        lend    = {1'b0, loff} + {1'b0, len};
        cfg_bad = (len == '0) || (ctrl.apt == APT_RSVD) ||
                  (lend > (LEN_W+1)'(ctrl.dsel ? DMEM_WORDS : IMEM_WORDS));
    end

    // state after a word completes: next word, next chunk, or done
    always_comb begin
        if (cnt == LEN_W'(1)) adv_st = (rem == LEN_W'(1)) ? S_IDLE : S_CHECK;
        else                  adv_st = cur.to_ext ? S_LRD : S_EXT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            cur        <= '0;
            lptr       <= '0;
            eptr       <= '0;
            rem        <= '0;
            cnt        <= '0;
            wbuf       <= '0;
            err_cfg    <= 1'b0;
            err_prot   <= 1'b0;
            fault_addr <= '0;
            irq        <= 1'b0;
        end else begin
            irq <= 1'b0;
            unique case (st)
                S_IDLE: if (go_q) begin
                    err_prot <= 1'b0;
                    if (cfg_bad) begin
                        err_cfg <= 1'b1;
                    end else begin
                        err_cfg <= 1'b0;
                        cur     <= ctrl;
                        lptr    <= loff[LA_W-1:0];
                        eptr    <= {ext_word, 2'b00};
                        rem     <= len;
                        st      <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    if (allow) begin
                        cnt <= chunk_n;
                        st  <= cur.to_ext ? S_LRD : S_EXT;
                    end else begin
                        err_prot   <= 1'b1;
                        fault_addr <= eptr;
                        irq        <= 1'b1;
                        st         <= S_IDLE;
                    end
                end
                S_LRD:  st <= S_LCAP;
                S_LCAP: begin
                    wbuf <= lmem_rdata;
                    st   <= S_EXT;
                end
                S_EXT: if (ext_ack) begin
                    if (cur.to_ext) begin
                        lptr <= lptr + LA_W'(1);
                        eptr <= eptr + AW'(4);
                        rem  <= rem - LEN_W'(1);
                        cnt  <= cnt - LEN_W'(1);
                        st   <= adv_st;
                    end else begin
                        wbuf <= ext_rdata;
                        st   <= S_LWR;
                    end
                end
                S_LWR: begin
                    lptr <= lptr + LA_W'(1);
                    eptr <= eptr + AW'(4);
                    rem  <= rem - LEN_W'(1);
                    cnt  <= cnt - LEN_W'(1);
                    st   <= adv_st;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy         = (st != S_IDLE);
    assign ext_req      = (st == S_EXT);
    assign ext_we       = cur.to_ext;
    assign ext_aperture = cur.apt;
    assign ext_addr     = eptr;
    assign ext_wdata    = wbuf;
    assign lmem_re      = (st == S_LRD);
    assign lmem_we      = (st == S_LWR);
    assign lmem_sel     = cur.dsel;
    assign lmem_addr    = lptr;
    assign lmem_wdata   = wbuf;
endmodule

// File: rtl/pdl_checker.sv
module pdl_checker (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        ext_req,
    input logic        ext_ack,
    input logic [31:0] ext_addr,
    input logic [1:0]  ext_aperture,
    input logic        lmem_re,
    input logic        lmem_we,
    input logic        err_cfg,
    input logic        err_prot,
    input logic        irq
);
    // R2: the reserved aperture never reaches the external port
    p_apt_legal_r2: assert property (@(posedge clk) disable iff (rst)
        ext_req |-> (ext_aperture != 2'd3));

    // R10: a pending request holds its address until acknowledged
    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr)));

    // R8: memory traffic only while busy
    p_access_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (ext_req || lmem_we || lmem_re) |-> busy);

    // R9: a configuration error never leaves the engine running
    p_cfg_idle_r9: assert property (@(posedge clk) disable iff (rst)
        err_cfg |-> (!busy && !ext_req && !lmem_we));

    // R7: the interrupt is a single-cycle pulse
    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R7: interrupt only with a stopped, protection-faulted transfer
    p_irq_fault_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (err_prot && !busy));

    // R7/R9: the two error kinds never coexist
    p_err_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(err_cfg && err_prot));
endmodule

bind prot_dma_loader pdl_checker u_chk (
    .clk(clk), .rst(rst), .busy(busy), .ext_req(ext_req), .ext_ack(ext_ack),
    .ext_addr(ext_addr), .ext_aperture(ext_aperture), .lmem_re(lmem_re),
    .lmem_we(lmem_we), .err_cfg(err_cfg), .err_prot(err_prot), .irq(irq)
);

// File: tb/prot_dma_loader_tb.sv
module prot_dma_loader_tb;
    localparam int IMW = 32;
    localparam int DMW = 16;
    localparam int CHW = 4;
    localparam int EXW = 256;
    localparam int LA_W = 5;
    localparam int RA_W = 5;

    typedef struct packed {
        logic        to_ext;
        logic        dsel;
        logic [1:0]  apt;
        logic [1:0]  pl;
        logic [7:0]  loff;
        logic [11:0] ext;
        logic [7:0]  len;
        logic [1:0]  exp_err;   // 0 none, 1 config, 2 protection
        logic [7:0]  moved;
        logic [11:0] fault;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,2'd1,2'd0,8'd0, 12'h000,8'd10,2'd0,8'd10,12'h000,4'd3},  // R3 R6 multi-chunk in
        '{1'b1,1'b1,2'd0,2'd0,8'd2, 12'h200,8'd5, 2'd0,8'd5, 12'h000,4'd4},  // R4 out from data
        '{1'b1,1'b0,2'd2,2'd0,8'd0, 12'h000,8'd2, 2'd2,8'd0, 12'h000,4'd5},  // R5 no write perm
        '{1'b0,1'b1,2'd1,2'd1,8'd0, 12'h100,8'd3, 2'd2,8'd0, 12'h100,4'd5},  // R5 level too low
        '{1'b0,1'b1,2'd1,2'd2,8'd0, 12'h100,8'd3, 2'd0,8'd3, 12'h000,4'd5},  // R5 level enough
        '{1'b0,1'b0,2'd0,2'd0,8'd20,12'h0F0,8'd8, 2'd2,8'd4, 12'h100,4'd7},  // R7 partial copy kept
        '{1'b0,1'b0,2'd1,2'd0,8'd0, 12'h000,8'd0, 2'd1,8'd0, 12'h000,4'd9},  // R9 zero length
        '{1'b0,1'b1,2'd1,2'd0,8'd14,12'h200,8'd3, 2'd1,8'd0, 12'h000,4'd9},  // R9 past end
        '{1'b0,1'b1,2'd1,2'd0,8'd13,12'h200,8'd3, 2'd0,8'd3, 12'h000,4'd9},  // R9 ends on last word
        '{1'b0,1'b0,2'd3,2'd0,8'd0, 12'h000,8'd1, 2'd1,8'd0, 12'h000,4'd2},  // R2 reserved aperture
        '{1'b1,1'b0,2'd2,2'd2,8'd4, 12'h120,8'd6, 2'd0,8'd6, 12'h000,4'd4},  // R4 out from instr
        '{1'b0,1'b1,2'd1,2'd2,8'd0, 12'h1F8,8'd4, 2'd2,8'd0, 12'h1F8,4'd6}   // R6 chunk straddles
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [RA_W-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic ext_req, ext_we, ext_ack = 1'b0;
    logic [1:0] ext_aperture;
    logic [31:0] ext_addr, ext_wdata, ext_rdata = '0;
    logic lmem_re, lmem_we, lmem_sel;
    logic [LA_W-1:0] lmem_addr;
    logic [31:0] lmem_wdata, lmem_rdata = '0;
    logic busy, err_cfg, err_prot, irq;
    logic [31:0] fault_addr;

    always #2 clk = ~clk;  // 250 MHz

    prot_dma_loader #(.IMEM_WORDS(IMW), .DMEM_WORDS(DMW), .CHUNK_WORDS(CHW), .NREG(4)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .ext_req(ext_req), .ext_we(ext_we), .ext_aperture(ext_aperture), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_ack(ext_ack), .ext_rdata(ext_rdata),
        .lmem_re(lmem_re), .lmem_we(lmem_we), .lmem_sel(lmem_sel), .lmem_addr(lmem_addr),
        .lmem_wdata(lmem_wdata), .lmem_rdata(lmem_rdata), .busy(busy), .err_cfg(err_cfg),
        .err_prot(err_prot), .fault_addr(fault_addr), .irq(irq)
    );

    logic [31:0] ext_mem [EXW];
    logic [31:0] imem [IMW];
    logic [31:0] dmem [DMW];
    logic [31:0] ext_s [EXW];
    logic [31:0] im_s [IMW];
    logic [31:0] dm_s [DMW];

    // memory models: one-cycle acknowledge, one-cycle local read latency (R10)
    always @(posedge clk) begin
        if (rst) begin
            ext_ack <= 1'b0;
        end else if (ext_req && !ext_ack) begin
            ext_ack <= 1'b1;
            if (ext_we) ext_mem[ext_addr[9:2]] <= ext_wdata;
            else        ext_rdata <= ext_mem[ext_addr[9:2]];
        end else begin
            ext_ack <= 1'b0;
        end
        if (lmem_we) begin
            if (lmem_sel) dmem[lmem_addr[3:0]] <= lmem_wdata;
            else          imem[lmem_addr] <= lmem_wdata;
        end
        if (lmem_re) lmem_rdata <= lmem_sel ? dmem[lmem_addr[3:0]] : imem[lmem_addr];
    end

    // monitor, sampled away from the active edge
    logic mon_clr = 1'b0;
    logic [1:0] exp_apt = '0;
    logic exp_we = 1'b0;
    int n_ack = 0, n_lwe = 0, n_irq = 0, n_busy = 0, n_badapt = 0;
    always @(negedge clk) begin
        if (mon_clr) begin
            n_ack = 0; n_lwe = 0; n_irq = 0; n_busy = 0; n_badapt = 0;
        end else begin
            if (ext_ack) n_ack++;
            if (lmem_we) n_lwe++;
            if (irq) n_irq++;
            if (busy) n_busy++;
            if (ext_req && (ext_aperture != exp_apt || ext_we != exp_we)) n_badapt++;
        end
    end

    int tests = 0, fails = 0;
    bit done = 1'b0;

    task automatic chk(input logic ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = RA_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic clear_mon();
        @(posedge clk); mon_clr = 1'b1;
        @(posedge clk); mon_clr = 1'b0;
    endtask

    task automatic snapshot();
        for (int i = 0; i < EXW; i++) ext_s[i] = ext_mem[i];
        for (int i = 0; i < IMW; i++) im_s[i] = imem[i];
        for (int i = 0; i < DMW; i++) dm_s[i] = dmem[i];
    endtask

    task automatic start_vec(input vec_t v);
        exp_apt = v.apt; exp_we = v.to_ext;
        clear_mon();
        wr(1, 32'(v.loff));
        wr(2, 32'(v.ext));
        wr(3, 32'(v.len));
        wr(0, {24'h0, v.pl, v.apt, 1'b0, v.dsel, v.to_ext, 1'b1});  // R1 control layout
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        repeat (3) @(negedge clk);
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
    endtask

    // compare all memories with the snapshot updated by the expected moves (R3 R4)
    task automatic check_data(input vec_t v, input string rq);
        int bad;
        int eb;
        logic [31:0] e;
        bad = 0;
        eb = int'(v.ext) / 4;
        for (int i = 0; i < EXW; i++) begin
            e = ext_s[i];
            if (v.to_ext && i >= eb && i < eb + int'(v.moved))
                e = v.dsel ? dm_s[int'(v.loff) + i - eb] : im_s[int'(v.loff) + i - eb];
            if (ext_mem[i] !== e) bad++;
        end
        for (int i = 0; i < IMW; i++) begin
            e = im_s[i];
            if (!v.to_ext && !v.dsel && i >= int'(v.loff) && i < int'(v.loff) + int'(v.moved))
                e = ext_s[eb + i - int'(v.loff)];
            if (imem[i] !== e) bad++;
        end
        for (int i = 0; i < DMW; i++) begin
            e = dm_s[i];
            if (!v.to_ext && v.dsel && i >= int'(v.loff) && i < int'(v.loff) + int'(v.moved))
                e = ext_s[eb + i - int'(v.loff)];
            if (dmem[i] !== e) bad++;
        end
        chk(bad == 0, rq, "memory words differing", 32'(bad), 32'd0);
    endtask

    task automatic run_vec(input vec_t v, input string rq);
        snapshot();
        start_vec(v);
        wait_idle();
        chk(err_cfg == (v.exp_err == 2'd1), rq, "err_cfg", 32'(err_cfg), 32'(v.exp_err == 2'd1));
        chk(err_prot == (v.exp_err == 2'd2), rq, "err_prot", 32'(err_prot), 32'(v.exp_err == 2'd2));
        if (v.exp_err == 2'd2)
            chk(fault_addr == 32'(v.fault), rq, "fault_addr", fault_addr, 32'(v.fault));
        chk(n_irq == (v.exp_err == 2'd2 ? 1 : 0), rq, "irq pulses", 32'(n_irq),
            32'(v.exp_err == 2'd2 ? 1 : 0));
        chk(n_ack == int'(v.moved), rq, "external accesses", 32'(n_ack), 32'(v.moved));
        chk(n_lwe == (v.to_ext ? 0 : int'(v.moved)), rq, "local writes", 32'(n_lwe),
            32'(v.to_ext ? 0 : int'(v.moved)));
        chk(n_badapt == 0, rq, "aperture/direction on requests", 32'(n_badapt), 32'd0);
        check_data(v, rq);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        string rq;
        vec_t v;
        for (int i = 0; i < EXW; i++) ext_mem[i] = 32'hE000_0000 + 32'(i);
        for (int i = 0; i < IMW; i++) imem[i] = 32'hA000_0000 + 32'(i);
        for (int i = 0; i < DMW; i++) dmem[i] = 32'hD000_0000 + 32'(i);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk(!busy && !ext_req && !lmem_we && !lmem_re, "R11", "idle after reset",
            {busy, ext_req, lmem_we, lmem_re}, 32'd0);
        chk(!err_cfg && !err_prot && !irq, "R11", "flags after reset",
            {err_cfg, err_prot, irq}, 32'd0);

        // R1 regions: 0x000-0x0FF read pl0; 0x100-0x1FF rw pl2; 0x200-0x27F rw pl0
        wr(8, 32'h000);  wr(9, 32'h0FF);  wr(10, 32'h1);
        wr(12, 32'h100); wr(13, 32'h1FF); wr(14, 32'hB);
        wr(16, 32'h200); wr(17, 32'h27F); wr(18, 32'h3);

        for (int k = 0; k < NV; k++) begin
            v = VECS[k];
            rq = $sformatf("R%0d", v.rq);
            run_vec(v, rq);
        end

        // R8: start while busy is ignored; busy spans the whole transfer
        v = VECS[0];
        snapshot();
        start_vec(v);
        repeat (6) @(negedge clk);
        chk(busy == 1'b1, "R8", "busy mid-transfer", 32'(busy), 32'd1);
        wr(0, 32'h0000_0023);  // start, outward, aperture 2: must be ignored
        wait_idle();
        chk(n_busy == 33, "R8", "busy cycles for 10 words in 3 chunks", 32'(n_busy), 32'd33);
        chk(n_ack == 10 && n_badapt == 0, "R8", "no second transfer", 32'(n_ack), 32'd10);
        check_data(v, "R8");
        repeat (8) @(negedge clk);
        chk(!busy && n_ack == 10, "R8", "still idle after ignored start", 32'(busy), 32'd0);

        // R11: reset clears flags and regions; a previously allowed read is now denied
        v = VECS[NV-1];
        run_vec(v, "R6");
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(!err_prot && !err_cfg && !busy, "R11", "flags cleared by reset",
            {err_prot, err_cfg, busy}, 32'd0);
        v = VECS[4];
        v.exp_err = 2'd2; v.moved = 8'd0; v.fault = 12'h100;
        run_vec(v, "R11");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule